// File: doc/BRIEF.md
# Fully Associative Translation Table with Probe

This block holds the page translation table that a system coprocessor manages by software. It has 16 slots, each keeping one high word (virtual page pair number and address-space identifier), two low words (the physical frames of the even and odd pages) and a page-size mask. Software prepares those four staging words elsewhere and then issues one of three commands: store them into a slot it names, store them into a pseudo-randomly picked slot, or search the table for a slot matching a high word.

The random slot comes from a free-running cycle counter taken modulo the count of slots that are not pinned. Slots below the pinned count are never picked. A search compares the virtual page pair field and honours a global flag that makes a slot match under any identifier. The search reports the lowest matching slot, or a miss code. It also returns the stored words of the slot it found.

Each accepted command takes one clock edge. A state machine records which command it just finished and raises `done` for one cycle. Its states are `ST_IDLE` (no command finished last edge), `ST_ACK_WIDX` (indexed store finished), `ST_ACK_WRND` (random store finished) and `ST_ACK_PROBE` (search finished). On every edge, an accepted command moves the machine to the state of that command. Any other cycle returns it to `ST_IDLE`, so states can follow one another back to back.

Top module: `tlb_ctrl`

## Requirements
- R1: After reset, `done` is 0, `probe_index` is 0, the hit data outputs are 0, and every slot is invalid, so a search misses until a slot is written.
- R2: An indexed store (`cmd_op` = 01) writes `entry_hi`, `entry_lo0`, `entry_lo1` and `page_mask` into the slot given by `index_sel`. A later search that hits that slot returns the same four words on `hit_hi`, `hit_lo0`, `hit_lo1` and `hit_mask`.
- R3: A random store (`cmd_op` = 10) writes slot `wired_cnt + (count_val mod (16 - wired_cnt))` when `wired_cnt` < 16, so slots below `wired_cnt` are never chosen.
- R4: When `wired_cnt` is 16 or more, a random store writes slot 15.
- R5: A search (`cmd_op` = 11) matches a valid slot whose bits 31:13 equal `entry_hi` bits 31:13 and whose bits 7:0 (identifier) equal `entry_hi` bits 7:0. Bits 12:0 other than the identifier take no part in the compare.
- R6: A slot is global when bit 0 of both stored low words was 1 at write time. A global slot matches on bits 31:13 alone. If only one of the two bits was 1, the slot is not global.
- R7: When several slots match, the search reports the lowest slot number.
- R8: On a hit, `probe_index` holds the slot number with bit 31 clear and all other upper bits 0. On a miss, `probe_index` is 0x80000000 and the four hit data outputs are 0.
- R9: `done` goes high for exactly the one cycle after the edge that accepts a command, and at no other time. `probe_index` and the hit data outputs change only on a search.
- R10: `cmd_op` = 00 with `cmd_valid` high is a no-operation. It changes no slot, raises no `done` and leaves the search outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 00 none, 01 indexed store, 10 random store, 11 search |
| entry_hi | input | 32 | Staging high word: page pair bits 31:13, identifier bits 7:0 |
| entry_lo0 | input | 32 | Staging low word, even page; bit 0 is its global bit |
| entry_lo1 | input | 32 | Staging low word, odd page; bit 0 is its global bit |
| page_mask | input | 32 | Staging page-size mask |
| index_sel | input | 4 | Target slot of an indexed store |
| wired_cnt | input | 5 | Number of pinned low slots |
| count_val | input | 32 | Free-running cycle counter |
| done | output | 1 | One-cycle completion pulse |
| probe_index | output | 32 | Search result: slot number, or 0x80000000 on a miss |
| hit_hi | output | 32 | Stored high word of the slot found |
| hit_lo0 | output | 32 | Stored even low word of the slot found |
| hit_lo1 | output | 32 | Stored odd low word of the slot found |
| hit_mask | output | 32 | Stored mask of the slot found |

## Verification
The search is tried against several kinds of high word:
- One that differs only in the identifier, which separates an identifier mismatch from a hit.
- One that differs only in bits 12:8 or bit 12, which shows those bits are left out of the compare.
- One that differs in bit 13, which shows the page pair field starts there.

Global slots are tried with both low-word global bits set and with only one set, which separates the AND from an OR. Duplicate entries in slots 12, 4 and 9 separate lowest-index priority from last-written or highest-index choices. Random stores are tried with zero pinned slots, a mid-range pinned count, and pinned counts of 15, 16 and 31, which expose errors in the modulo and fallback arithmetic.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    localparam int WORD_W  = 32;
    localparam int VPN_LSB = 13;
    localparam int VPN_W   = WORD_W - VPN_LSB;
    localparam int ASID_W  = 8;
    localparam int GLB_BIT = 0;

    typedef enum logic [1:0] {
        OP_NONE   = 2'b00,
        OP_WR_IDX = 2'b01,
        OP_WR_RND = 2'b10,
        OP_PROBE  = 2'b11
    } tlb_op_e;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_ACK_WIDX  = 2'd1,
        ST_ACK_WRND  = 2'd2,
        ST_ACK_PROBE = 2'd3
    } tlb_state_e;

    typedef struct packed {
        logic              valid;
        logic              global;
        logic [WORD_W-1:0] hi;
        logic [WORD_W-1:0] lo0;
        logic [WORD_W-1:0] lo1;
        logic [WORD_W-1:0] mask;
    } tlb_entry_t;

endpackage

// File: rtl/tlb_entry_store.sv
module tlb_entry_store
    import tlb_pkg::*;
#(
    parameter int NUM_ENTRIES = 16,
    parameter int IDX_W       = $clog2(NUM_ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_slot,
    input  tlb_entry_t       wr_entry,
    output tlb_entry_t       slots_o [NUM_ENTRIES]
);

    tlb_entry_t slot_q [NUM_ENTRIES];

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q[g] <= '0;
            end else if (wr_en && (wr_slot == IDX_W'(g))) begin
                slot_q[g] <= wr_entry;
            end
        end
        assign slots_o[g] = slot_q[g];
    end

endmodule

// File: rtl/tlb_match.sv
module tlb_match
    import tlb_pkg::*;
#(
    parameter int NUM_ENTRIES = 16,
    parameter int IDX_W       = $clog2(NUM_ENTRIES)
) (
    input  logic [NUM_ENTRIES-1:0] slot_valid,
    input  logic [NUM_ENTRIES-1:0] slot_global,
    input  logic [VPN_W-1:0]       slot_vpn  [NUM_ENTRIES],
    input  logic [ASID_W-1:0]      slot_asid [NUM_ENTRIES],
    input  logic [VPN_W-1:0]       key_vpn,
    input  logic [ASID_W-1:0]      key_asid,
    output logic                   hit,
    output logic [IDX_W-1:0]       hit_slot
);

    logic [NUM_ENTRIES-1:0] match_vec;

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_cmp
        assign match_vec[g] = slot_valid[g]
                            && (slot_vpn[g] == key_vpn)
                            && (slot_global[g] || (slot_asid[g] == key_asid));
    end

    // lowest index wins: scan downward so the last assignment is the lowest
    always_comb begin
        hit_slot = '0;
        for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
            if (match_vec[i]) begin
                hit_slot = IDX_W'(i);
            end
        end
    end

    assign hit = |match_vec;

endmodule

// File: rtl/tlb_slot_pick.sv
module tlb_slot_pick
    import tlb_pkg::*;
#(
    parameter int NUM_ENTRIES = 16,
    parameter int IDX_W       = $clog2(NUM_ENTRIES)
) (
    input  logic [WORD_W-1:0] count_val,
    input  logic [IDX_W:0]    wired_cnt,
    output logic [IDX_W-1:0]  slot
);

    logic [WORD_W-1:0] span;
    logic [WORD_W-1:0] rem;

    always_comb begin
        span = '0;
        rem  = '0;
        if (wired_cnt >= (IDX_W+1)'(NUM_ENTRIES)) begin
            slot = IDX_W'(NUM_ENTRIES - 1);
        end else begin
            span = WORD_W'(NUM_ENTRIES) - WORD_W'(wired_cnt);
            rem  = count_val % span;
            slot = IDX_W'(WORD_W'(wired_cnt) + rem);
        end
    end

endmodule

// File: rtl/tlb_ctrl.sv
module tlb_ctrl
    import tlb_pkg::*;
#(
    parameter int NUM_ENTRIES = 16,
    parameter int IDX_W       = $clog2(NUM_ENTRIES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_valid,
    input  logic [1:0]           cmd_op,
    input  logic [31:0]          entry_hi,
    input  logic [31:0]          entry_lo0,
    input  logic [31:0]          entry_lo1,
    input  logic [31:0]          page_mask,
    input  logic [IDX_W-1:0]     index_sel,
    input  logic [IDX_W:0]       wired_cnt,
    input  logic [31:0]          count_val,
    output logic                 done,
    output logic [31:0]          probe_index,
    output logic [31:0]          hit_hi,
    output logic [31:0]          hit_lo0,
    output logic [31:0]          hit_lo1,
    output logic [31:0]          hit_mask
);

    localparam logic [WORD_W-1:0] MISS_CODE = {1'b1, {(WORD_W-1){1'b0}}};

    tlb_op_e    op;
    tlb_state_e state_q, state_d;

    assign op = tlb_op_e'(cmd_op);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state: each accepted command lands in its own acknowledge state
    always_comb begin
        state_d = ST_IDLE;
        if (cmd_valid) begin
            unique case (op)
                OP_NONE:   state_d = ST_IDLE;
                OP_WR_IDX: state_d = ST_ACK_WIDX;
                OP_WR_RND: state_d = ST_ACK_WRND;
                OP_PROBE:  state_d = ST_ACK_PROBE;
            endcase
        end
    end

    // outputs of the state machine
    always_comb begin
        unique case (state_q)
            ST_IDLE:      done = 1'b0;
            ST_ACK_WIDX,
            ST_ACK_WRND,
            ST_ACK_PROBE: done = 1'b1;
        endcase
    end

    // table write path
    logic             wr_en;
    logic [IDX_W-1:0] rnd_slot;
    logic [IDX_W-1:0] wr_slot;
    tlb_entry_t       wr_entry;
    tlb_entry_t       tbl [NUM_ENTRIES];

    tlb_slot_pick #(.NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W)) pick_i (
        .count_val (count_val),
        .wired_cnt (wired_cnt),
        .slot      (rnd_slot)
    );

    assign wr_en   = cmd_valid && ((op == OP_WR_IDX) || (op == OP_WR_RND));
    assign wr_slot = (op == OP_WR_IDX) ? index_sel : rnd_slot;

    always_comb begin
        wr_entry        = '0;
        wr_entry.valid  = 1'b1;
        wr_entry.global = entry_lo0[GLB_BIT] & entry_lo1[GLB_BIT];
        wr_entry.hi     = entry_hi;
        wr_entry.lo0    = entry_lo0;
        wr_entry.lo1    = entry_lo1;
        wr_entry.mask   = page_mask;
    end

    tlb_entry_store #(.NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W)) store_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_slot  (wr_slot),
        .wr_entry (wr_entry),
        .slots_o  (tbl)
    );

    // search path
    logic [NUM_ENTRIES-1:0] s_valid;
    logic [NUM_ENTRIES-1:0] s_global;
    logic [VPN_W-1:0]       s_vpn  [NUM_ENTRIES];
    logic [ASID_W-1:0]      s_asid [NUM_ENTRIES];
    logic                   hit;
    logic [IDX_W-1:0]       hit_slot;
    tlb_entry_t             hit_entry;

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_fields
        assign s_valid[g]  = tbl[g].valid;
        assign s_global[g] = tbl[g].global;
        assign s_vpn[g]    = tbl[g].hi[WORD_W-1:VPN_LSB];
        assign s_asid[g]   = tbl[g].hi[ASID_W-1:0];
    end

    tlb_match #(.NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W)) match_i (
        .slot_valid  (s_valid),
        .slot_global (s_global),
        .slot_vpn    (s_vpn),
        .slot_asid   (s_asid),
        .key_vpn     (entry_hi[WORD_W-1:VPN_LSB]),
        .key_asid    (entry_hi[ASID_W-1:0]),
        .hit         (hit),
        .hit_slot    (hit_slot)
    );

    assign hit_entry = tbl[hit_slot];

    // registered search result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            probe_index <= '0;
            hit_hi      <= '0;
            hit_lo0     <= '0;
            hit_lo1     <= '0;
            hit_mask    <= '0;
        end else if (cmd_valid && (op == OP_PROBE)) begin
            if (hit) begin
                probe_index <= WORD_W'(hit_slot);
                hit_hi      <= hit_entry.hi;
                hit_lo0     <= hit_entry.lo0;
                hit_lo1     <= hit_entry.lo1;
                hit_mask    <= hit_entry.mask;
            end else begin
                probe_index <= MISS_CODE;
                hit_hi      <= '0;
                hit_lo0     <= '0;
                hit_lo1     <= '0;
                hit_mask    <= '0;
            end
        end
    end

endmodule

// File: rtl/tlb_ctrl_chk.sv
module tlb_ctrl_chk #(
    parameter int IDX_W = 4
) (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_valid,
    input logic [1:0]  cmd_op,
    input logic        done,
    input logic [31:0] probe_index,
    input logic [31:0] hit_hi,
    input logic [31:0] hit_lo0,
    input logic [31:0] hit_lo1,
    input logic [31:0] hit_mask
);

    logic accepted;
    logic searching;
    assign accepted  = cmd_valid && (cmd_op != 2'b00);
    assign searching = cmd_valid && (cmd_op == 2'b11);

    p_done_follows_cmd_r9: assert property (@(posedge clk) disable iff (!rst_n)
        accepted |=> done);

    p_no_stray_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !accepted |=> !done);

    p_miss_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
        probe_index[31] |-> (probe_index[30:0] == 31'd0) && (hit_hi == 32'd0)
                            && (hit_lo0 == 32'd0) && (hit_lo1 == 32'd0)
                            && (hit_mask == 32'd0));

    p_hit_slot_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !probe_index[31] |-> (probe_index[30:IDX_W] == '0));

    p_result_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !searching |=> $stable(probe_index) && $stable(hit_hi) && $stable(hit_lo0)
                       && $stable(hit_lo1) && $stable(hit_mask));

endmodule

bind tlb_ctrl tlb_ctrl_chk #(.IDX_W(IDX_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_op      (cmd_op),
    .done        (done),
    .probe_index (probe_index),
    .hit_hi      (hit_hi),
    .hit_lo0     (hit_lo0),
    .hit_lo1     (hit_lo1),
    .hit_mask    (hit_mask)
);

// File: tb/tlb_ctrl_tb_top.sv
module tlb_ctrl_tb_top;

    localparam logic [31:0] MISS = 32'h8000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'b00;
    logic [31:0] entry_hi = '0, entry_lo0 = '0, entry_lo1 = '0, page_mask = '0;
    logic [3:0]  index_sel = '0;
    logic [4:0]  wired_cnt = '0;
    logic [31:0] count_val = '0;
    logic        done;
    logic [31:0] probe_index, hit_hi, hit_lo0, hit_lo1, hit_mask;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    tlb_ctrl dut_i (
        .clk (clk), .rst_n (rst_n), .cmd_valid (cmd_valid), .cmd_op (cmd_op),
        .entry_hi (entry_hi), .entry_lo0 (entry_lo0), .entry_lo1 (entry_lo1),
        .page_mask (page_mask), .index_sel (index_sel), .wired_cnt (wired_cnt),
        .count_val (count_val), .done (done), .probe_index (probe_index),
        .hit_hi (hit_hi), .hit_lo0 (hit_lo0), .hit_lo1 (hit_lo1), .hit_mask (hit_mask)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        cmd_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // drive one command for one edge; returns at the following falling edge
    task automatic send(input logic [1:0] op, input logic [31:0] hi, input logic [31:0] l0,
                        input logic [31:0] l1, input logic [31:0] pm, input logic [3:0] idx,
                        input logic [4:0] wc, input logic [31:0] cnt);
        cmd_op = op; entry_hi = hi; entry_lo0 = l0; entry_lo1 = l1; page_mask = pm;
        index_sel = idx; wired_cnt = wc; count_val = cnt;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic write_idx(input logic [31:0] hi, input logic [31:0] l0,
                             input logic [31:0] l1, input logic [3:0] idx);
        send(2'b01, hi, l0, l1, 32'h0, idx, 5'd0, 32'h0);
    endtask

    task automatic probe(input logic [31:0] hi);
        send(2'b11, hi, 32'h0, 32'h0, 32'h0, 4'd0, 5'd0, 32'h0);
    endtask

    function automatic logic [31:0] exp_rnd(input logic [31:0] cnt, input int wc);
        if (wc >= 16) return 32'd15;
        return 32'(wc) + (cnt % 32'(16 - wc));
    endfunction

    task automatic t_reset();
        do_reset();
        check("R1", "done after reset", {31'd0, done}, 32'd0);
        check("R1", "probe_index after reset", probe_index, 32'd0);
        check("R1", "hit_hi after reset", hit_hi, 32'd0);
        probe(32'h0000_0000);
        check("R1", "empty table search", probe_index, MISS);
    endtask

    task automatic t_write_index();
        do_reset();
        send(2'b01, 32'hABCD_E00A, 32'h0000_1236, 32'h0000_4567, 32'h0000_6000,
             4'd5, 5'd0, 32'h0);
        check("R9", "done after indexed store", {31'd0, done}, 32'd1);
        check("R9", "store leaves probe_index", probe_index, 32'd0);
        @(negedge clk);
        check("R9", "done drops", {31'd0, done}, 32'd0);
        probe(32'hABCD_E00A);
        check("R2", "indexed slot", probe_index, 32'd5);
        check("R2", "hi word", hit_hi, 32'hABCD_E00A);
        check("R2", "lo0 word", hit_lo0, 32'h0000_1236);
        check("R2", "lo1 word", hit_lo1, 32'h0000_4567);
        check("R2", "mask word", hit_mask, 32'h0000_6000);
        check("R9", "done after search", {31'd0, done}, 32'd1);
    endtask

    task automatic rnd_case(input logic [31:0] cnt, input int wc, input logic [31:0] hi);
        send(2'b10, hi, 32'h0, 32'h0, 32'h0, 4'd0, 5'(wc), cnt);
        probe(hi);
        if (wc >= 16) check("R4", "fallback slot", probe_index, exp_rnd(cnt, wc));
        else          check("R3", "random slot", probe_index, exp_rnd(cnt, wc));
    endtask

    task automatic t_write_random();
        do_reset();
        rnd_case(32'd100, 4, 32'h1000_0001);
        rnd_case(32'h1234_5677, 0, 32'h2000_0002);
        rnd_case(32'd3, 10, 32'h3000_0003);
        rnd_case(32'hFFFF_FFFF, 15, 32'h4000_0004);
    endtask

    task automatic t_wired_overflow();
        do_reset();
        rnd_case(32'd7, 16, 32'h5000_0005);
        rnd_case(32'd9, 31, 32'h6000_0006);
    endtask

    task automatic t_asid();
        do_reset();
        write_idx(32'h7777_6011, 32'h1, 32'h0, 4'd2);
        probe(32'h7777_6022);
        check("R5", "other identifier misses", probe_index, MISS);
        probe(32'h7777_7F11);
        check("R5", "bits 12:8 ignored", probe_index, 32'd2);
        probe(32'h7777_4011);
        check("R5", "bit 13 compared", probe_index, MISS);
    endtask

    task automatic t_global();
        do_reset();
        write_idx(32'h8888_0033, 32'h1, 32'h1, 4'd6);
        probe(32'h8888_0044);
        check("R6", "global slot any identifier", probe_index, 32'd6);
        write_idx(32'h9999_0033, 32'h1, 32'h0, 4'd7);
        probe(32'h9999_0044);
        check("R6", "one global bit not global", probe_index, MISS);
        probe(32'h9999_0033);
        check("R6", "non-global own identifier", probe_index, 32'd7);
    endtask

    task automatic t_priority();
        do_reset();
        write_idx(32'hAAAA_0055, 32'h0, 32'h0, 4'd12);
        write_idx(32'hAAAA_0055, 32'h0, 32'h0, 4'd4);
        write_idx(32'hAAAA_0055, 32'h0, 32'h0, 4'd9);
        probe(32'hAAAA_0055);
        check("R7", "lowest slot wins", probe_index, 32'd4);
        write_idx(32'hBBBB_0055, 32'h0, 32'h0, 4'd4);
        probe(32'hAAAA_0055);
        check("R7", "next lowest after overwrite", probe_index, 32'd9);
    endtask

    task automatic t_miss();
        do_reset();
        write_idx(32'hCCCC_0001, 32'h5, 32'h7, 4'd3);
        probe(32'hCCCC_0001);
        check("R8", "hit before miss", probe_index, 32'd3);
        probe(32'hDDDD_0001);
        check("R8", "miss code", probe_index, MISS);
        check("R8", "miss clears lo0", hit_lo0, 32'd0);
    endtask

    task automatic t_nop();
        do_reset();
        write_idx(32'hEEEE_0009, 32'h0, 32'h0, 4'd1);
        probe(32'hEEEE_0009);
        send(2'b00, 32'hF0F0_0009, 32'h0, 32'h0, 32'h0, 4'd1, 5'd0, 32'h0);
        check("R10", "no done on no-op", {31'd0, done}, 32'd0);
        check("R10", "no-op keeps result", probe_index, 32'd1);
        probe(32'hEEEE_0009);
        check("R10", "no-op kept slot", probe_index, 32'd1);
        probe(32'hF0F0_0009);
        check("R10", "no-op wrote nothing", probe_index, MISS);
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        t_reset();
        t_write_index();
        t_write_random();
        t_wired_overflow();
        t_asid();
        t_global();
        t_priority();
        t_miss();
        t_nop();
        finished = 1'b1;
        report();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end

endmodule